// File: doc/BRIEF.md
# Two-Tier Lookahead Wide Counter

A 64-bit synchronous up-counter made from eight 8-bit slices. Inside each slice, every bit's toggle condition is one wide AND of the slice enable and the lower bits of that slice. Each slice flags "full" when all eight of its bits are one, whether or not it is enabled. The slices form two groups of four. Inside a group, each slice's enable is one AND of the group enable and the full flags of the slices below it. The full flags do not ripple from slice to slice.

The low group (bits 31:0) takes the external count enable. Its group carry is that enable ANDed with all four of its full flags. The group carry is the enable of the high group (bits 63:32). This is the only serial link, so the longest gating path is two AND levels between the groups plus the AND levels inside a slice. The high group's carry appears as the counter's carry output. The enable of each slice comes out on a debug bus. A test-only load port lets a testbench place the counter near a wide boundary without stepping there one count at a time.

Top module: `tiered_carry_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, the count becomes zero at that edge. This applies whatever `tst_load` and `cnt_en` are.
- R2: With `rst` at 0 and `tst_load` at 1, the count takes `tst_value` at the edge. It does not count at that edge, even when `cnt_en` is 1.
- R3: With `rst` and `tst_load` at 0 and `cnt_en` at 1, the count increases by one modulo 2^64 at each edge. This includes carries across slice boundaries (multiples of 8 bits) and across the group boundary between bit 31 and bit 32.
- R4: With `rst` and `tst_load` at 0 and `cnt_en` at 0, all 64 bits keep their value at the edge.
- R5: Bit k of `slice_en_dbg` is the enable of slice k, the slice that holds count bits 8k+7 down to 8k. It is 1 exactly when `cnt_en` is 1 and every count bit below bit 8k is 1. Slice 0's enable is `cnt_en` itself. The bus is combinational from the current count and `cnt_en`.
- R6: `carry_out` is combinational. It is 1 exactly when `cnt_en` is 1 and all 64 count bits are 1.
- R7: When the count is all ones and the counter counts (`cnt_en` 1, `tst_load` 0), the count wraps to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| cnt_en | input | 1 | Count enable |
| tst_load | input | 1 | Test-only synchronous load strobe |
| tst_value | input | 64 | Value written by the test load |
| count | output | 64 | Current count |
| carry_out | output | 1 | High-group carry: enabled and all ones |
| slice_en_dbg | output | 8 | Per-slice enable, bit k for slice k |

## Verification
The hard cases are the carries into the high group and the final wrap. Counting up to them from zero would take up to 2^64 cycles. The bench uses the test load to place the count a few steps below 0x00000000_FFFFFFFF, 0x000000FF_FFFFFFFF and the all-ones value. It then counts through each boundary while comparing the count, the per-slice enables and the carry against a 64-bit reference. Patterns with a zero bit just below a slice boundary show that a high slice's enable needs every lower bit to be one, not only the bits of its neighbour.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  parameter int SLICE_W = 8;
  parameter int SLICES_PER_GRP = 4;
  parameter int GRP_CNT = 2;
  localparam int GRP_W = SLICE_W * SLICES_PER_GRP;
  localparam int CNT_W = GRP_W * GRP_CNT;
  localparam int SLICE_CNT = SLICES_PER_GRP * GRP_CNT;

  // Toggle vector for one slice: bit i flips when en and all bits below i are 1.
  // Each bit is a single wide AND (parallel gating), no chain through bits.
  function automatic logic [SLICE_W-1:0] slice_toggles(input logic [SLICE_W-1:0] q,
                                                       input logic en);
    logic [SLICE_W-1:0] t;
    logic [SLICE_W-1:0] low_mask;
    for (int i = 0; i < SLICE_W; i++) begin
      low_mask = (SLICE_W'(1) << i) - SLICE_W'(1);
      t[i] = en & (&(q | ~low_mask));
    end
    return t;
  endfunction

  // Lookahead slice enables inside a group: slice k needs the group enable
  // and the full flags of slices 0..k-1, formed as one AND each.
  function automatic logic [SLICES_PER_GRP-1:0] group_lookahead(
      input logic grp_en, input logic [SLICES_PER_GRP-1:0] full);
    logic [SLICES_PER_GRP-1:0] e;
    logic [SLICES_PER_GRP-1:0] below;
    for (int k = 0; k < SLICES_PER_GRP; k++) begin
      below = (SLICES_PER_GRP'(1) << k) - SLICES_PER_GRP'(1);
      e[k] = grp_en & (&(full | ~below));
    end
    return e;
  endfunction
endpackage

// File: rtl/tcc_slice.sv
module tcc_slice
  import tcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [SLICE_W-1:0] ld_val,
  input  logic               en,
  output logic [SLICE_W-1:0] q,
  output logic               full
);
  logic [SLICE_W-1:0] toggles;

  assign toggles = slice_toggles(q, en);
  // Full flag is independent of en so the group can look ahead on it.
  assign full = &q;

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else          q <= q ^ toggles;
  end

  // R3: an enabled slice advances by one (modulo its width)
  a_r3_slice_step: assert property (@(posedge clk) disable iff (rst)
    (en && !ld) |=> (q == $past(q) + SLICE_W'(1)));
  // R4: a disabled slice keeps its bits
  a_r4_slice_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> $stable(q));
endmodule

// File: rtl/tcc_group.sv
module tcc_group
  import tcc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld,
  input  logic [GRP_W-1:0]          ld_val,
  input  logic                      grp_en,
  output logic [GRP_W-1:0]          q,
  output logic [SLICES_PER_GRP-1:0] slc_en,
  output logic                      grp_carry
);
  logic [SLICES_PER_GRP-1:0] slc_full;

  assign slc_en    = group_lookahead(grp_en, slc_full);
  assign grp_carry = grp_en & (&slc_full);

  for (genvar k = 0; k < SLICES_PER_GRP; k++) begin : g_slice
    tcc_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld),
      .ld_val (ld_val[k*SLICE_W +: SLICE_W]),
      .en     (slc_en[k]),
      .q      (q[k*SLICE_W +: SLICE_W]),
      .full   (slc_full[k])
    );
    if (k > 0) begin : g_chk
      // R5: a slice is only enabled when its lower neighbour is enabled and full
      a_r5_lookahead_gate: assert property (@(posedge clk) disable iff (rst)
        slc_en[k] |-> (slc_en[k-1] && slc_full[k-1]));
    end
  end

  // R6: the group carry needs the top slice enabled and full
  a_r6_group_carry: assert property (@(posedge clk) disable iff (rst)
    grp_carry |-> (slc_en[SLICES_PER_GRP-1] && slc_full[SLICES_PER_GRP-1]));
endmodule

// File: rtl/tiered_carry_counter.sv
module tiered_carry_counter
  import tcc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cnt_en,
  input  logic                 tst_load,
  input  logic [CNT_W-1:0]     tst_value,
  output logic [CNT_W-1:0]     count,
  output logic                 carry_out,
  output logic [SLICE_CNT-1:0] slice_en_dbg
);
  // Serial chain between groups: group g's enable is group g-1's carry.
  logic [GRP_CNT:0] grp_link;

  assign grp_link[0] = cnt_en;
  assign carry_out   = grp_link[GRP_CNT];

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    tcc_group u_grp (
      .clk       (clk),
      .rst       (rst),
      .ld        (tst_load),
      .ld_val    (tst_value[g*GRP_W +: GRP_W]),
      .grp_en    (grp_link[g]),
      .q         (count[g*GRP_W +: GRP_W]),
      .slc_en    (slice_en_dbg[g*SLICES_PER_GRP +: SLICES_PER_GRP]),
      .grp_carry (grp_link[g+1])
    );
  end

  // R1: reset clears the whole count
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (count == '0));
  // R2: load takes priority over counting
  a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
    tst_load |=> (count == $past(tst_value)));
  // R6: carry out only at all ones while enabled
  a_r6_carry_out_ones: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> (cnt_en && (count == '1)));
  // R7: the final carry is followed by a wrap to zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (carry_out && !tst_load) |=> (count == '0));
endmodule

// File: tb/tiered_carry_counter_test.sv
module tiered_carry_counter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cnt_en;
  logic        tst_load;
  logic [63:0] tst_value;
  logic [63:0] count;
  logic        carry_out;
  logic [7:0]  slice_en_dbg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tiered_carry_counter uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .tst_load(tst_load),
    .tst_value(tst_value), .count(count), .carry_out(carry_out),
    .slice_en_dbg(slice_en_dbg)
  );

  // Entries: {enable, start value}
  localparam logic [64:0] VEC [12] = '{
    {1'b1, 64'h0000_0000_0000_0000},
    {1'b1, 64'h0000_0000_0000_00FF},
    {1'b1, 64'h0000_0000_0000_FFFF},
    {1'b1, 64'h0000_0000_FFFF_FFFF},
    {1'b1, 64'h0000_00FF_FFFF_FFFF},
    {1'b1, 64'h7FFF_FFFF_FFFF_FFFF},
    {1'b1, 64'hFFFF_FF7F_FFFF_FFFF},
    {1'b1, 64'h1234_5678_9ABC_DEFF},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'h00FF_00FF_00FF_00FF},
    {1'b1, 64'hFFFF_FFFF_7FFF_FFFF}
  };

  function automatic logic [7:0] exp_slice_en(input logic [63:0] v, input logic en);
    logic [7:0] r;
    logic [63:0] m;
    for (int k = 0; k < 8; k++) begin
      m = (64'h1 << (8 * k)) - 64'h1;
      r[k] = en && ((v & m) == m);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_val(input logic [63:0] v);
    @(negedge clk);
    tst_load = 1'b1; tst_value = v; cnt_en = 1'b0;
    @(negedge clk);
    tst_load = 1'b0;
  endtask

  // One counting cycle with comb checks before the edge and count check after.
  task automatic step(input logic en, input logic [63:0] ref_v);
    logic [63:0] nxt;
    cnt_en = en;
    #1;
    chk(slice_en_dbg == exp_slice_en(ref_v, en), "R5 slice enables",
        {56'h0, slice_en_dbg}, {56'h0, exp_slice_en(ref_v, en)});
    chk(carry_out == (en && ref_v == '1), "R6 carry_out",
        {63'h0, carry_out}, {63'h0, (en && ref_v == '1)});
    nxt = en ? ref_v + 64'h1 : ref_v;
    @(negedge clk);
    chk(count == nxt, en ? "R3/R7 increment" : "R4 hold", count, nxt);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    rst = 1'b1; cnt_en = 1'b0; tst_load = 1'b0; tst_value = '0;
    repeat (3) @(negedge clk);
    chk(count == 64'h0, "R1 reset state", count, 64'h0);
    rst = 1'b0;

    // Table walk: load, then one step, compare with reference.
    for (int i = 0; i < 12; i++) begin
      load_val(VEC[i][63:0]);
      chk(count == VEC[i][63:0], "R2 load", count, VEC[i][63:0]);
      step(VEC[i][64], VEC[i][63:0]);
    end

    // R2: load wins over enable
    @(negedge clk);
    tst_load = 1'b1; tst_value = 64'hAAAA_5555_0F0F_F0F0; cnt_en = 1'b1;
    @(negedge clk);
    tst_load = 1'b0; cnt_en = 1'b0;
    chk(count == 64'hAAAA_5555_0F0F_F0F0, "R2 load over enable", count,
        64'hAAAA_5555_0F0F_F0F0);

    // R1: reset wins over load and enable
    rst = 1'b1; tst_load = 1'b1; cnt_en = 1'b1; tst_value = 64'h1;
    @(negedge clk);
    rst = 1'b0; tst_load = 1'b0; cnt_en = 1'b0;
    chk(count == 64'h0, "R1 reset priority", count, 64'h0);

    // R3: run across the group boundary
    r = 64'h0000_0000_FFFF_FFFA;
    load_val(r);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, r);
      r = r + 64'h1;
    end

    // R4: hold for several cycles mid-run
    for (int i = 0; i < 4; i++) step(1'b0, r);

    // R7: run through the final wrap
    r = 64'hFFFF_FFFF_FFFF_FFFC;
    load_val(r);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, r);
      r = r + 64'h1;
    end
    cnt_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule